// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a simple host port and a single rank of DDR SDRAM with four internal banks. The host offers one request at a time (bank, row, column, direction and an optional close-after-access flag) and holds it until the sequencer grants it. The sequencer then drives the command pins (chip select, RAS#, CAS#, WE#, bank address and the address bus) to open the row if needed and to issue the read or write. It keeps the row-to-column and precharge spacing, and it issues refreshes from a free-running interval timer.

Each bank has a valid bit and an open-row register. A request to the open row of a bank goes straight to the column command. A request to another row of an open bank first closes that bank. A request to a closed bank activates the row. Address line 10 is the auto-precharge flag on column commands and the all-banks flag on precharge. When the refresh timer fires, the pending refresh takes priority over host requests. The sequencer closes every bank, refreshes and waits out the refresh cycle time. After reset it waits a power-up delay, closes all banks, refreshes twice and programs the extended and base mode registers before it grants anything.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is asserted and during the power-up wait after it, chip select is high (deselect) and no request is granted.
- R2: Start-up issues, in this order: PRECHARGE with A10=1; AUTO REFRESH T_RP cycles later; a second AUTO REFRESH T_RFC later; LOAD MODE with BA=01 and A=0 T_RFC later; and LOAD MODE with BA=00 T_MRD later. The base mode word carries the burst code in A[2:0] (2→1, 4→2, 8→3), A3=0 (sequential) and the CAS code in A[6:4] (latency 2→010, 2.5→110).
- R3: No request is granted before the base mode register load has been issued. The first grant comes T_MRD cycles after it.
- R4: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. Deselect drives all four high. An idle sequencer drives NOP.
- R5: A request to a closed bank issues ACTIVATE (BA=bank, A=row) in the cycle after the grant. The column command follows exactly T_RCD cycles after the ACTIVATE.
- R6: A request to the open row of a bank issues its column command in the cycle after the grant, with no ACTIVATE.
- R7: A request to another row of an open bank issues PRECHARGE with A10=0 and BA=bank in the cycle after the grant. ACTIVATE follows T_RP cycles later and the column command T_RCD after that.
- R8: A column command carries the column on A[8:0] and the close-after flag on A10. With that flag set, the bank counts as closed: the next request is granted T_RP cycles after the column command, and a request to the same row starts with ACTIVATE.
- R9: The refresh timer fires every REF_INTERVAL cycles. With all banks closed and no traffic, consecutive AUTO REFRESH commands are exactly REF_INTERVAL cycles apart.
- R10: A refresh that finds any bank open first issues PRECHARGE with A10=1, then AUTO REFRESH T_RP later. Afterwards all banks count as closed.
- R11: A pending refresh takes priority over a waiting request. That request is granted exactly T_RFC cycles after the AUTO REFRESH.
- R12: The grant is high only while req_valid is high, and it never lasts two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_autopre | input | 1 | Close the bank after this access |
| req_grant | output | 1 | Request accepted this cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ROW_W | Address bus |

## Verification
The bench targets the three paths a request can take (closed bank, row hit, row miss). A table that forgot to record rows would re-activate on a hit. A table that never compared rows would read the wrong row on a miss. The bench also checks exact command spacing at start-up and around refresh. An off-by-one in the wait counter shows up as a shifted REFRESH or ACTIVATE, and a refresh that skipped the all-bank precharge would leave a stale row that turns the next access into a false hit. The auto-precharge flag is checked through the next access to the same row, which must activate again after T_RP. A request held during a refresh must not be granted early, and a refresh interval that is off by one cycle is caught by measuring the distance between idle refreshes.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}  (R4)
  localparam logic [3:0] CMD_LMR   = 4'b0000;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_WR    = 4'b0100;
  localparam logic [3:0] CMD_RD    = 4'b0101;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_DESEL = 4'b1111;

  typedef enum logic [3:0] {
    ST_WAIT, ST_IPRE, ST_IREF1, ST_IREF2, ST_IEMR, ST_IMR,
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_RPRE, ST_REF
  } seq_state_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Base mode word: burst code [2:0], sequential [3], CAS code [6:4]  (R2)
  function automatic logic [15:0] mode_word(input int burst, input int cas_x2);
    logic [2:0] bl_code;
    logic [2:0] cl_code;
    bl_code = (burst == 8) ? 3'd3 : (burst == 4) ? 3'd2 : 3'd1;
    cl_code = (cas_x2 == 4) ? 3'b010 : (cas_x2 == 5) ? 3'b110 : 3'b011;
    return {9'd0, cl_code, 1'b0, bl_code};
  endfunction

endpackage

// File: rtl/ddr_wait_cnt.sv
module ddr_wait_cnt #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer #(
  parameter int REF_INTERVAL = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int RT_W = $clog2(REF_INTERVAL + 1);

  logic [RT_W-1:0] cnt_q;
  logic [RT_W-1:0] cnt_d;
  logic            pend_d;
  logic            tick;

  always_comb begin
    tick   = enable && (cnt_q == '0);
    cnt_d  = (!enable || tick) ? RT_W'(REF_INTERVAL - 1) : cnt_q - 1'b1;
    pend_d = enable && (tick || (pending && !ack));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RT_W'(REF_INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic              close_en,
  input  logic              close_all,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              q_open,
  output logic              q_hit,
  output logic              any_open
);
  localparam int NUM_BANKS = 1 << BANK_W;

  logic [NUM_BANKS-1:0] valid_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic row_en;
    assign sel    = (upd_bank == BANK_W'(b));
    assign row_en = open_en && sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       valid_q[b] <= 1'b0;
      else if (close_all)               valid_q[b] <= 1'b0;
      else if (close_en && sel)         valid_q[b] <= 1'b0;
      else if (row_en)                  valid_q[b] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[b] <= '0;
      else if (row_en) row_q[b] <= upd_row;
    end
  end

  assign q_open   = valid_q[q_bank];
  assign q_hit    = q_open && (row_q[q_bank] == q_row);
  assign any_open = |valid_q;
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 10,
  parameter int T_MRD        = 2,
  parameter int PWRUP_CYC    = 26600,
  parameter int REF_INTERVAL = 1040,
  parameter int BURST_LEN    = 4,
  parameter int CAS_X2       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic              req_grant,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_addr
);
  localparam int CNT_W = $clog2(max_int(max_int(PWRUP_CYC, T_RFC),
                                        max_int(max_int(T_RCD, T_RP), T_MRD)) + 1);
  localparam logic [15:0] MODE_WORD = mode_word(BURST_LEN, CAS_X2);
  localparam int AP_BIT = 10;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  seq_state_t state_q, state_d, ret_q, ret_d;
  logic init_done_q, init_done_d;
  logic lat_write_q, lat_ap_q;
  logic [BANK_W-1:0] lat_bank_q;
  logic [ROW_W-1:0]  lat_row_q;
  logic [COL_W-1:0]  lat_col_q;

  logic             wait_load, wait_done;
  logic [CNT_W-1:0] wait_val;
  logic             tbl_open, tbl_close, tbl_close_all;
  logic             q_open, q_hit, any_open;
  logic             ref_pend, ref_ack;
  logic [3:0]       cmd;

  ddr_wait_cnt #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC)) u_wait (
    .clk(clk), .rst_n(srst_n), .load(wait_load), .load_val(wait_val), .done(wait_done)
  );

  ddr_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(srst_n), .open_en(tbl_open), .close_en(tbl_close),
    .close_all(tbl_close_all), .upd_bank(lat_bank_q), .upd_row(lat_row_q),
    .q_bank(req_bank), .q_row(req_row), .q_open(q_open), .q_hit(q_hit),
    .any_open(any_open)
  );

  ddr_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(srst_n), .enable(init_done_q), .ack(ref_ack), .pending(ref_pend)
  );

  // next-state and command decode
  always_comb begin
    state_d       = state_q;
    ret_d         = ret_q;
    init_done_d   = init_done_q;
    wait_load     = 1'b0;
    wait_val      = '0;
    tbl_open      = 1'b0;
    tbl_close     = 1'b0;
    tbl_close_all = 1'b0;
    ref_ack       = 1'b0;
    req_grant     = 1'b0;
    cmd           = CMD_NOP;
    cmd_ba        = '0;
    cmd_addr      = '0;
    unique case (state_q)
      ST_WAIT: begin
        if (ret_q == ST_IPRE) cmd = CMD_DESEL;            // power-up wait, R1
        if (wait_done) state_d = ret_q;
      end
      ST_IPRE, ST_RPRE: begin                             // close all, R2 R10
        cmd              = CMD_PRE;
        cmd_addr[AP_BIT] = 1'b1;
        tbl_close_all    = 1'b1;
        wait_load        = 1'b1;
        wait_val         = CNT_W'(T_RP - 1);
        ret_d            = (state_q == ST_IPRE) ? ST_IREF1 : ST_REF;
        state_d          = ST_WAIT;
      end
      ST_IREF1, ST_IREF2, ST_REF: begin
        cmd       = CMD_REF;
        ref_ack   = (state_q == ST_REF);
        wait_load = 1'b1;
        wait_val  = CNT_W'(T_RFC - 1);
        ret_d     = (state_q == ST_IREF1) ? ST_IREF2 :
                    (state_q == ST_IREF2) ? ST_IEMR : ST_IDLE;
        state_d   = ST_WAIT;
      end
      ST_IEMR: begin
        cmd       = CMD_LMR;
        cmd_ba    = BANK_W'(1);
        wait_load = 1'b1;
        wait_val  = CNT_W'(T_MRD - 1);
        ret_d     = ST_IMR;
        state_d   = ST_WAIT;
      end
      ST_IMR: begin
        cmd         = CMD_LMR;
        cmd_addr    = MODE_WORD[ROW_W-1:0];
        wait_load   = 1'b1;
        wait_val    = CNT_W'(T_MRD - 1);
        ret_d       = ST_IDLE;
        init_done_d = 1'b1;
        state_d     = ST_WAIT;
      end
      ST_IDLE: begin
        if (ref_pend) begin                               // R11
          state_d = any_open ? ST_RPRE : ST_REF;
        end else if (req_valid) begin
          req_grant = 1'b1;
          state_d   = q_hit ? ST_COL : (q_open ? ST_PRE : ST_ACT);
        end
      end
      ST_PRE: begin                                       // R7
        cmd       = CMD_PRE;
        cmd_ba    = lat_bank_q;
        tbl_close = 1'b1;
        wait_load = 1'b1;
        wait_val  = CNT_W'(T_RP - 1);
        ret_d     = ST_ACT;
        state_d   = ST_WAIT;
      end
      ST_ACT: begin                                       // R5
        cmd       = CMD_ACT;
        cmd_ba    = lat_bank_q;
        cmd_addr  = lat_row_q;
        tbl_open  = 1'b1;
        wait_load = 1'b1;
        wait_val  = CNT_W'(T_RCD - 1);
        ret_d     = ST_COL;
        state_d   = ST_WAIT;
      end
      ST_COL: begin                                       // R8
        cmd                   = lat_write_q ? CMD_WR : CMD_RD;
        cmd_ba                = lat_bank_q;
        cmd_addr[COL_W-1:0]   = lat_col_q;
        cmd_addr[AP_BIT]      = lat_ap_q;
        if (lat_ap_q) begin
          tbl_close = 1'b1;
          wait_load = 1'b1;
          wait_val  = CNT_W'(T_RP - 1);
          ret_d     = ST_IDLE;
          state_d   = ST_WAIT;
        end else begin
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q     <= ST_WAIT;
      ret_q       <= ST_IPRE;
      init_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      ret_q       <= ret_d;
      init_done_q <= init_done_d;
    end
  end

  // request latch, enabled by the grant
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lat_write_q <= 1'b0;
      lat_ap_q    <= 1'b0;
      lat_bank_q  <= '0;
      lat_row_q   <= '0;
      lat_col_q   <= '0;
    end else if (req_grant) begin
      lat_write_q <= req_write;
      lat_ap_q    <= req_autopre;
      lat_bank_q  <= req_bank;
      lat_row_q   <= req_row;
      lat_col_q   <= req_col;
    end
  end
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
  parameter int BANK_W = 2,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_grant,
  input logic              cmd_cs_n,
  input logic              cmd_ras_n,
  input logic              cmd_cas_n,
  input logic              cmd_we_n,
  input logic [BANK_W-1:0] cmd_ba
);
  logic [3:0]  c;
  logic        is_act, is_pre, is_ref, is_col, is_real;
  logic [15:0] since_act, since_pre, since_ref;
  logic        mr_seen;

  assign c       = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign is_act  = (c == 4'b0011);
  assign is_pre  = (c == 4'b0010);
  assign is_ref  = (c == 4'b0001);
  assign is_col  = (c == 4'b0101) || (c == 4'b0100);
  assign is_real = !cmd_cs_n && (c != 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 16'hFFFF;
      since_pre <= 16'hFFFF;
      since_ref <= 16'hFFFF;
      mr_seen   <= 1'b0;
    end else begin
      since_act <= is_act ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 1'b1);
      since_pre <= is_pre ? 16'd1 : (since_pre == 16'hFFFF ? since_pre : since_pre + 1'b1);
      since_ref <= is_ref ? 16'd1 : (since_ref == 16'hFFFF ? since_ref : since_ref + 1'b1);
      if (c == 4'b0000 && cmd_ba == '0) mr_seen <= 1'b1;
    end
  end

  AST_DESEL_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs_n |-> (cmd_ras_n && cmd_cas_n && cmd_we_n)); // R4
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> req_valid); // R12
  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |=> !req_grant); // R12
  AST_GRANT_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> mr_seen); // R3
  AST_RCD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act >= 16'(T_RCD))); // R5
  AST_RP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_ref) |-> (since_pre >= 16'(T_RP))); // R7
  AST_RFC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    is_real |-> (since_ref >= 16'(T_RFC))); // R11
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
  .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
  .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba)
);

// File: tb/tb_ddr_cmd_seq.sv
module tb_ddr_cmd_seq;
  localparam int T_RCD = 3, T_RP = 3, T_RFC = 7, T_MRD = 2;
  localparam int PWRUP = 20, REF_INT = 400;
  localparam int WDOG = 20000;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_autopre, req_grant;
  logic [1:0] req_bank;
  logic [12:0] req_row;
  logic [8:0] req_col;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;

  ddr_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
                .PWRUP_CYC(PWRUP), .REF_INTERVAL(REF_INT), .BURST_LEN(4), .CAS_X2(5)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_grant(req_grant), .cmd_cs_n(cs_n),
    .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_ba(ba), .cmd_addr(addr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // command monitor
  logic [3:0]  m_cmd  [256];
  logic [1:0]  m_ba   [256];
  logic [12:0] m_addr [256];
  int          m_cyc  [256];
  int m_n = 0;
  int rd_i = 0;
  int grants_early = 0;
  bit mr_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP && {cs_n, ras_n, cas_n, we_n} != C_DES && m_n < 256) begin
        m_cmd[m_n]  = {cs_n, ras_n, cas_n, we_n};
        m_ba[m_n]   = ba;
        m_addr[m_n] = addr;
        m_cyc[m_n]  = cyc;
        m_n++;
      end
      if (req_grant && !mr_seen) grants_early++;
      if ({cs_n, ras_n, cas_n, we_n} == C_LMR && ba == 2'd0) mr_seen = 1'b1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nxt(output int i);
    while (rd_i >= m_n) begin
      @(negedge clk);
      #1;
    end
    i = rd_i;
    rd_i++;
  endtask

  task automatic drive(input bit w, input int b, input int r, input int c, input bit ap);
    req_valid   = 1'b1;
    req_write   = w;
    req_bank    = 2'(b);
    req_row     = 13'(r);
    req_col     = 9'(c);
    req_autopre = ap;
  endtask

  task automatic wait_grant(output int g);
    #1;
    while (!req_grant) @(negedge clk);
    g = cyc;
  endtask

  task automatic do_req(input bit w, input int b, input int r, input int c,
                        input bit ap, input bit hold, output int g);
    drive(w, b, r, c, ap);
    wait_grant(g);
    if (hold) begin
      @(negedge clk);
      chk("R12 grant lasts one cycle", int'(req_grant), 0);
      #1 req_valid = 1'b0;
    end else begin
      @(posedge clk);
      #1 req_valid = 1'b0;
    end
  endtask

  // R1 R2 R3 R4 R5
  task automatic t_startup();
    int i, p, g;
    drive(1'b0, 0, 5, 7, 1'b0);
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 cs_n in reset", int'(cs_n), 1);
      chk("R1 no grant in reset", int'(req_grant), 0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R1 deselect during power-up", int'(cs_n), 1);
    end
    nxt(i);
    chk("R2 first is PRECHARGE", int'(m_cmd[i]), int'(C_PRE));
    chk("R2 A10 all banks", int'(m_addr[i][10]), 1);
    p = m_cyc[i];
    nxt(i);
    chk("R2 refresh 1", int'(m_cmd[i]), int'(C_REF));
    chk("R2 refresh 1 spacing", m_cyc[i] - p, T_RP);
    p = m_cyc[i];
    nxt(i);
    chk("R2 refresh 2", int'(m_cmd[i]), int'(C_REF));
    chk("R2 refresh 2 spacing", m_cyc[i] - p, T_RFC);
    p = m_cyc[i];
    nxt(i);
    chk("R2 extended mode load", int'(m_cmd[i]), int'(C_LMR));
    chk("R2 extended mode BA", int'(m_ba[i]), 1);
    chk("R2 extended mode word", int'(m_addr[i]), 0);
    chk("R2 extended mode spacing", m_cyc[i] - p, T_RFC);
    p = m_cyc[i];
    nxt(i);
    chk("R2 base mode load", int'(m_cmd[i]), int'(C_LMR));
    chk("R2 base mode BA", int'(m_ba[i]), 0);
    chk("R2 base mode word", int'(m_addr[i]), 'h062);
    chk("R2 base mode spacing", m_cyc[i] - p, T_MRD);
    p = m_cyc[i];
    wait_grant(g);
    @(posedge clk);
    #1 req_valid = 1'b0;
    chk("R3 no grant before mode load", grants_early, 0);
    chk("R3 first grant timing", g - p, T_MRD);
    nxt(i);
    chk("R5 closed bank ACTIVATE", int'(m_cmd[i]), int'(C_ACT));
    chk("R5 ACTIVATE row", int'(m_addr[i]), 5);
    chk("R5 ACTIVATE after grant", m_cyc[i] - g, 1);
    p = m_cyc[i];
    nxt(i);
    chk("R5 READ after ACTIVATE", int'(m_cmd[i]), int'(C_RD));
    chk("R5 row-to-column delay", m_cyc[i] - p, T_RCD);
    chk("R8 READ column and A10", int'(m_addr[i]), 7);
    repeat (2) @(negedge clk);
    chk("R4 idle drives NOP", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
  endtask

  // R6 R12
  task automatic t_hit();
    int i, g;
    do_req(1'b0, 0, 5, 9, 1'b0, 1'b1, g);
    nxt(i);
    chk("R6 hit goes straight to READ", int'(m_cmd[i]), int'(C_RD));
    chk("R6 hit column timing", m_cyc[i] - g, 1);
    chk("R6 hit column", int'(m_addr[i]), 9);
  endtask

  // R7
  task automatic t_miss();
    int i, g, p;
    do_req(1'b1, 0, 6, 3, 1'b0, 1'b0, g);
    nxt(i);
    chk("R7 miss PRECHARGE", int'(m_cmd[i]), int'(C_PRE));
    chk("R7 single-bank A10", int'(m_addr[i][10]), 0);
    chk("R7 PRECHARGE bank", int'(m_ba[i]), 0);
    chk("R7 PRECHARGE timing", m_cyc[i] - g, 1);
    p = m_cyc[i];
    nxt(i);
    chk("R7 ACTIVATE new row", int'(m_addr[i]), 6);
    chk("R7 precharge delay", m_cyc[i] - p, T_RP);
    p = m_cyc[i];
    nxt(i);
    chk("R7 WRITE command", int'(m_cmd[i]), int'(C_WR));
    chk("R7 WRITE spacing", m_cyc[i] - p, T_RCD);
  endtask

  // R8
  task automatic t_autopre();
    int i, g, w;
    do_req(1'b1, 1, 2, 'h1F, 1'b1, 1'b0, g);
    nxt(i);
    chk("R8 ACTIVATE bank 1", int'(m_cmd[i]), int'(C_ACT));
    nxt(i);
    chk("R8 WRITE with close flag", int'(m_cmd[i]), int'(C_WR));
    chk("R8 column plus A10", int'(m_addr[i]), 'h41F);
    chk("R8 WRITE bank", int'(m_ba[i]), 1);
    w = m_cyc[i];
    do_req(1'b0, 1, 2, 1, 1'b0, 1'b0, g);
    chk("R8 next grant after T_RP", g - w, T_RP);
    nxt(i);
    chk("R8 same row re-activated", int'(m_cmd[i]), int'(C_ACT));
    nxt(i);
    chk("R8 READ after re-activate", int'(m_cmd[i]), int'(C_RD));
    // leave bank 2 open too
    do_req(1'b0, 2, 9, 0, 1'b0, 1'b0, g);
    nxt(i);
    nxt(i);
  endtask

  // R10 R11
  task automatic t_refresh_busy();
    int i, g, p;
    i = -1;
    while (i < 0 || !(m_cmd[i] == C_PRE && m_addr[i][10])) nxt(i);
    p = m_cyc[i];
    drive(1'b0, 0, 6, 4, 1'b0);
    wait_grant(g);
    @(posedge clk);
    #1 req_valid = 1'b0;
    nxt(i);
    chk("R10 REFRESH after close-all", int'(m_cmd[i]), int'(C_REF));
    chk("R10 REFRESH spacing", m_cyc[i] - p, T_RP);
    chk("R11 grant held off by refresh", g - m_cyc[i], T_RFC);
    nxt(i);
    chk("R10 rows forgotten after refresh", int'(m_cmd[i]), int'(C_ACT));
    chk("R10 ACTIVATE row", int'(m_addr[i]), 6);
    p = m_cyc[i];
    nxt(i);
    chk("R11 READ after refresh", int'(m_addr[i]), 4);
    chk("R5 READ spacing after refresh", m_cyc[i] - p, T_RCD);
  endtask

  // R9 R10
  task automatic t_interval();
    int i, a, b;
    nxt(i);
    chk("R10 refresh with open bank precharges", int'(m_cmd[i]), int'(C_PRE));
    nxt(i);
    chk("R9 refresh A", int'(m_cmd[i]), int'(C_REF));
    a = m_cyc[i];
    nxt(i);
    chk("R9 refresh B", int'(m_cmd[i]), int'(C_REF));
    b = m_cyc[i];
    chk("R9 B after A", b - a, REF_INT - T_RP);
    nxt(i);
    chk("R9 refresh C", int'(m_cmd[i]), int'(C_REF));
    chk("R9 idle refresh period", m_cyc[i] - b, REF_INT);
  endtask

  initial begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_autopre = 1'b0;
    req_bank = '0;
    req_row = '0;
    req_col = '0;
    t_startup();
    t_hit();
    t_miss();
    t_autopre();
    t_refresh_busy();
    t_interval();
    summary();
    $finish;
  end
endmodule